// File: doc/BRIEF.md
# Max-Log Soft-In Soft-Out Decoder for an 8-State Recursive Constituent Code

This block decodes one constituent code of an 8-state turbo code. A frame of per-bit soft values (systematic, parity and a priori) is written in over a valid/ready handshake. The block then produces one log-likelihood ratio per information bit using the max-log approximation. It keeps no branch metric store: each branch metric is recomputed from the stored soft inputs whenever a recursion needs it.

Once the last sample is accepted, a forward metric unit and a backward metric unit start together. Each unit advances one trellis step every two clock cycles and updates all eight states in the same pass. Both units write their metrics into their own metric memory. When the two recursions cross the middle of the frame, every step yields up to two LLRs: one on a forward lane and one on a backward lane. All LLRs are therefore complete after N steps, with no separate output pass. Interleaving, iteration control, termination bits and hard decisions are handled outside this block.

The frame capacity is the parameter `MAX_LEN`. A full-size deployment sets it to 12282. The default is kept small.

Top module: `maxlog_siso`

## Requirements
- R1: After reset, `inReady` is high and `llrValid0`, `llrValid1` and `done` are low. A sample is taken on each rising edge where `inValid` and `inReady` are both high. `inReady` falls after the edge that takes the frame's final sample, stays low while decoding, and is high again in the cycle `done` is high.
- R2: For a transition with information bit u and parity bit p (each 0 or 1), the branch metric is u·(sys+apr) + p·par. Here sys, par and apr are the signed `SW`-bit inputs of that bit position.
- R3: The state index is 4·s1 + 2·s2 + s3, where s1 is the most recent register bit. The feedback bit is a = u xor s2 xor s3. The parity is p = a xor s1 xor s3. The next state is 4·a + 2·s1 + s2.
- R4: Both recursions start with state 0 at 0 and every other state at −2^(MW−2). The backward start applies at the state boundary after the last bit.
- R5: The LLR of bit k is the largest alpha_k(s) + gamma + beta_(k+1)(s') over transitions with u=1, minus the largest such sum over transitions with u=0. Per-step normalisation does not change this value.
- R6: Each LLR is saturated to the signed `OW`-bit range [−2^(OW−1), 2^(OW−1)−1].
- R7: In step j of a frame of N bits, lane 0 carries bit j when j ≥ N−1−j. Lane 1 carries bit N−1−j when j > N−1−j. Every bit appears exactly once, and lane 1 is never valid without lane 0.
- R8: One step completes every two cycles, so lane 0 is never valid on two consecutive cycles. `done` is high for exactly one cycle, together with the last LLRs, on the 2N-th rising edge after the edge that accepted the final sample.
- R9: The frame ends when a sample with `inLast` high is taken, or when sample number `MAX_LEN` is taken, whichever comes first.
- R10: A frame that follows another frame is decoded with freshly initialised metrics. Its LLRs do not depend on the previous frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Soft sample present |
| inReady | output | 1 | Block can take a sample |
| inLast | input | 1 | Sample is the last of its frame |
| inSys | input | SW | Systematic channel soft value, signed |
| inPar | input | SW | Parity channel soft value, signed |
| inApr | input | SW | A priori value, signed |
| llrValid0 | output | 1 | Lane 0 carries an LLR |
| llrIdx0 | output | AW | Bit position of lane 0 |
| llr0 | output | OW | Lane 0 LLR, signed |
| llrValid1 | output | 1 | Lane 1 carries an LLR |
| llrIdx1 | output | AW | Bit position of lane 1 |
| llr1 | output | OW | Lane 1 LLR, signed |
| done | output | 1 | Final LLRs of the frame are on the lanes |

## Verification
The properties take for granted that `inLast` is only meaningful while `inValid` is high. They also assume that soft inputs stay within their signed `SW`-bit range, so the `MW`-bit metrics never wrap and normalised values stay bounded. The stimulus offers samples only in the load phase and keeps `inValid` low from the final accepted sample until `done`. It uses values from the full signed range, including the extremes −32 and +31. Frames of 1 to 24 bits are swept exhaustively in length, and the capacity limit is reached both with and without `inLast`.

// File: rtl/siso_pkg.sv
package siso_pkg;

  localparam int NumStates = 8;

  typedef struct packed {
    logic wrSoft;
    logic initMetrics;
    logic issue;
    logic commit;
    logic fwdEmit;
    logic bwdEmit;
    logic middle;
    logic lastStep;
  } strobe_t;

  // state bits: [2]=s1 (newest), [1]=s2, [0]=s3
  function automatic logic feedbackBit(input logic [2:0] s, input logic u);
    return u ^ s[1] ^ s[0];
  endfunction

  function automatic logic [2:0] nextState(input logic [2:0] s, input logic u);
    return {feedbackBit(s, u), s[2], s[1]};
  endfunction

  function automatic logic parityOut(input logic [2:0] s, input logic u);
    return feedbackBit(s, u) ^ s[2] ^ s[0];
  endfunction

  // predecessor j of state ns (j is the dropped oldest bit)
  function automatic logic [2:0] prevState(input logic [2:0] ns, input logic j);
    return {ns[1], ns[0], j};
  endfunction

  function automatic logic inputOf(input logic [2:0] ns, input logic j);
    return ns[2] ^ ns[0] ^ j;
  endfunction

endpackage

// File: rtl/siso_ctrl.sv
module siso_ctrl
  import siso_pkg::*;
#(
  parameter int MAX_LEN = 2048,
  parameter int AW      = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inLast,
  output logic          inReady,
  output strobe_t       st,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] fwdIdx,
  output logic [AW-1:0] bwdIdx
);

  typedef enum logic [1:0] {Load, Issue, Commit} phase_t;

  phase_t        phase;
  logic [AW-1:0] cnt;
  logic [AW-1:0] lenM1;
  logic [AW-1:0] step;
  logic          accept;
  logic          frameEnd;

  assign accept   = (phase == Load) && inValid;
  assign frameEnd = inLast || (cnt == AW'(MAX_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= Load;
      cnt   <= '0;
      lenM1 <= '0;
      step  <= '0;
    end else begin
      case (phase)
        Load: begin
          if (accept) begin
            if (frameEnd) begin
              lenM1 <= cnt;
              cnt   <= '0;
              step  <= '0;
              phase <= Issue;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        Issue: phase <= Commit;
        Commit: begin
          if (step == lenM1) begin
            phase <= Load;
          end else begin
            step  <= step + 1'b1;
            phase <= Issue;
          end
        end
        default: phase <= Load;
      endcase
    end
  end

  always_comb begin
    inReady        = (phase == Load);
    wrAddr         = cnt;
    fwdIdx         = step;
    bwdIdx         = lenM1 - step;
    st.wrSoft      = accept;
    st.initMetrics = accept && frameEnd;
    st.issue       = (phase == Issue);
    st.commit      = (phase == Commit);
    st.fwdEmit     = (step >= bwdIdx);
    st.bwdEmit     = (step > bwdIdx);
    st.middle      = (step == bwdIdx);
    st.lastStep    = (step == lenM1);
  end

endmodule

// File: rtl/siso_datapath.sv
module siso_datapath
  import siso_pkg::*;
#(
  parameter int SW      = 6,
  parameter int MW      = 14,
  parameter int OW      = 10,
  parameter int MAX_LEN = 2048,
  parameter int AW      = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] fwdIdx,
  input  logic [AW-1:0] bwdIdx,
  input  logic [3*SW-1:0] inWord,
  output logic          llrValid0,
  output logic [AW-1:0] llrIdx0,
  output logic [OW-1:0] llr0,
  output logic          llrValid1,
  output logic [AW-1:0] llrIdx1,
  output logic [OW-1:0] llr1,
  output logic          done
);

  localparam int GW      = SW + 2;      // branch metric width
  localparam int LW      = MW + 2;      // path sum width
  localparam int NegI    = -(2 ** (MW - 2));
  localparam int SatHiI  = 2 ** (OW - 1) - 1;
  localparam int SatLoI  = -(2 ** (OW - 1));
  localparam logic [MW-1:0]        NegInit = NegI[MW-1:0];
  localparam logic signed [LW-1:0] MinSum  = {1'b1, {(LW-1){1'b0}}};

  typedef logic [NumStates-1:0][MW-1:0] metVec_t;
  typedef logic [3:0][GW-1:0]           gamVec_t;

  logic [3*SW-1:0] softMem  [MAX_LEN];
  metVec_t         alphaMem [MAX_LEN];
  metVec_t         betaMem  [MAX_LEN];

  logic [3*SW-1:0] softF, softB;
  metVec_t         alphaRd, betaRd;
  metVec_t         alphaReg, betaReg;
  metVec_t         alphaNext, betaNext;
  gamVec_t         gF, gB;
  logic signed [LW:0] llrF, llrB;

  function automatic logic signed [LW-1:0] wm(input logic [MW-1:0] v);
    return LW'($signed(v));
  endfunction

  function automatic logic signed [LW-1:0] wg(input logic [GW-1:0] v);
    return LW'($signed(v));
  endfunction

  // index {u,p}: metric u*(sys+apr) + p*par
  function automatic gamVec_t gammaSet(input logic [3*SW-1:0] w);
    logic signed [SW-1:0] sy, pa, ap;
    logic signed [GW-1:0] sa, pr;
    gamVec_t g;
    sy = w[3*SW-1:2*SW];
    pa = w[2*SW-1:SW];
    ap = w[SW-1:0];
    sa = GW'(sy) + GW'(ap);
    pr = GW'(pa);
    for (int c = 0; c < 4; c++) begin
      g[c] = (c[1] ? sa : '0) + (c[0] ? pr : '0);
    end
    return g;
  endfunction

  function automatic metVec_t fwdStep(input metVec_t a, input gamVec_t g);
    logic signed [LW-1:0] raw [NumStates];
    logic signed [LW-1:0] best, cand;
    logic [2:0] ps;
    logic       u, p;
    metVec_t    res;
    for (int ns = 0; ns < NumStates; ns++) begin
      best = MinSum;
      for (int j = 0; j < 2; j++) begin
        ps   = prevState(3'(ns), j[0]);
        u    = inputOf(3'(ns), j[0]);
        p    = parityOut(ps, u);
        cand = wm(a[ps]) + wg(g[{u, p}]);
        if (cand > best) best = cand;
      end
      raw[ns] = best;
    end
    for (int ns = 0; ns < NumStates; ns++) res[ns] = MW'(raw[ns] - raw[0]);
    return res;
  endfunction

  function automatic metVec_t bwdStep(input metVec_t b, input gamVec_t g);
    logic signed [LW-1:0] raw [NumStates];
    logic signed [LW-1:0] best, cand;
    logic [2:0] ns;
    logic       p;
    metVec_t    res;
    for (int s = 0; s < NumStates; s++) begin
      best = MinSum;
      for (int u = 0; u < 2; u++) begin
        ns   = nextState(3'(s), u[0]);
        p    = parityOut(3'(s), u[0]);
        cand = wm(b[ns]) + wg(g[{u[0], p}]);
        if (cand > best) best = cand;
      end
      raw[s] = best;
    end
    for (int s = 0; s < NumStates; s++) res[s] = MW'(raw[s] - raw[0]);
    return res;
  endfunction

  function automatic logic signed [LW:0] llrOf(input metVec_t a, input metVec_t b,
                                               input gamVec_t g);
    logic signed [LW-1:0] best1, best0, cand;
    logic [2:0] ns;
    logic       p;
    best1 = MinSum;
    best0 = MinSum;
    for (int s = 0; s < NumStates; s++) begin
      for (int u = 0; u < 2; u++) begin
        ns   = nextState(3'(s), u[0]);
        p    = parityOut(3'(s), u[0]);
        cand = wm(a[s]) + wg(g[{u[0], p}]) + wm(b[ns]);
        if (u == 1) begin
          if (cand > best1) best1 = cand;
        end else begin
          if (cand > best0) best0 = cand;
        end
      end
    end
    return (LW+1)'(best1) - (LW+1)'(best0);
  endfunction

  function automatic logic [OW-1:0] sat(input logic signed [LW:0] d);
    if (d > (LW+1)'(SatHiI)) return SatHiI[OW-1:0];
    if (d < (LW+1)'(SatLoI)) return SatLoI[OW-1:0];
    return d[OW-1:0];
  endfunction

  // memories: one write port for soft input, two read ports; metric stores
  always_ff @(posedge clk) begin
    if (st.wrSoft) softMem[wrAddr] <= inWord;
    if (st.issue) begin
      softF   <= softMem[fwdIdx];
      softB   <= softMem[bwdIdx];
      alphaRd <= alphaMem[bwdIdx];
      betaRd  <= betaMem[fwdIdx];
    end
    if (st.commit) begin
      alphaMem[fwdIdx] <= alphaReg;
      betaMem[bwdIdx]  <= betaReg;
    end
  end

  always_comb begin
    gF        = gammaSet(softF);
    gB        = gammaSet(softB);
    alphaNext = fwdStep(alphaReg, gF);
    betaNext  = bwdStep(betaReg, gB);
    llrF      = llrOf(alphaReg, st.middle ? betaReg : betaRd, gF);
    llrB      = llrOf(alphaRd, betaReg, gB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alphaReg  <= '0;
      betaReg   <= '0;
      llrValid0 <= 1'b0;
      llrValid1 <= 1'b0;
      done      <= 1'b0;
      llr0      <= '0;
      llr1      <= '0;
      llrIdx0   <= '0;
      llrIdx1   <= '0;
    end else begin
      if (st.initMetrics) begin
        for (int s = 0; s < NumStates; s++) begin
          alphaReg[s] <= (s == 0) ? '0 : NegInit;
          betaReg[s]  <= (s == 0) ? '0 : NegInit;
        end
      end else if (st.commit) begin
        alphaReg <= alphaNext;
        betaReg  <= betaNext;
      end
      llrValid0 <= st.commit && st.fwdEmit;
      llrValid1 <= st.commit && st.bwdEmit;
      done      <= st.commit && st.lastStep;
      if (st.commit) begin
        llr0    <= sat(llrF);
        llrIdx0 <= fwdIdx;
        llr1    <= sat(llrB);
        llrIdx1 <= bwdIdx;
      end
    end
  end

endmodule

// File: rtl/maxlog_siso.sv
module maxlog_siso
  import siso_pkg::*;
#(
  parameter int SW      = 6,
  parameter int MW      = 14,
  parameter int OW      = 10,
  parameter int MAX_LEN = 2048,
  localparam int AW     = $clog2(MAX_LEN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  input  logic          inLast,
  input  logic [SW-1:0] inSys,
  input  logic [SW-1:0] inPar,
  input  logic [SW-1:0] inApr,
  output logic          llrValid0,
  output logic [AW-1:0] llrIdx0,
  output logic [OW-1:0] llr0,
  output logic          llrValid1,
  output logic [AW-1:0] llrIdx1,
  output logic [OW-1:0] llr1,
  output logic          done
);

  strobe_t       st;
  logic [AW-1:0] wrAddr, fwdIdx, bwdIdx;

  siso_ctrl #(.MAX_LEN(MAX_LEN), .AW(AW)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .st(st), .wrAddr(wrAddr),
    .fwdIdx(fwdIdx), .bwdIdx(bwdIdx)
  );

  siso_datapath #(.SW(SW), .MW(MW), .OW(OW), .MAX_LEN(MAX_LEN), .AW(AW)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrAddr(wrAddr),
    .fwdIdx(fwdIdx), .bwdIdx(bwdIdx), .inWord({inSys, inPar, inApr}),
    .llrValid0(llrValid0), .llrIdx0(llrIdx0), .llr0(llr0),
    .llrValid1(llrValid1), .llrIdx1(llrIdx1), .llr1(llr1), .done(done)
  );

endmodule

// File: rtl/maxlog_siso_chk.sv
module maxlog_siso_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          inReady,
  input logic          inLast,
  input logic          llrValid0,
  input logic          llrValid1,
  input logic [AW-1:0] llrIdx0,
  input logic [AW-1:0] llrIdx1,
  input logic          done
);

  // R8
  done_with_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> llrValid0);

  // R7
  lanes_paired_chk: assert property (@(posedge clk) disable iff (!rstN)
    llrValid1 |-> (llrValid0 && (llrIdx1 < llrIdx0)));

  // R8
  step_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    llrValid0 |=> !llrValid0);

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady);

  // R1
  ready_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> inReady);

endmodule

bind maxlog_siso maxlog_siso_chk #(.AW(AW)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inLast(inLast), .llrValid0(llrValid0), .llrValid1(llrValid1),
  .llrIdx0(llrIdx0), .llrIdx1(llrIdx1), .done(done)
);

// File: tb/test_maxlog_siso.sv
module test_maxlog_siso;

  localparam int ClkPeriod = 10;
  localparam int SW = 6;
  localparam int MW = 14;
  localparam int OW = 10;
  localparam int ML = 64;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inLast = 1'b0;
  logic [SW-1:0] inSys = '0, inPar = '0, inApr = '0;
  logic          inReady, llrValid0, llrValid1, done;
  logic [AW-1:0] llrIdx0, llrIdx1;
  logic [OW-1:0] llr0, llr1;

  always #(ClkPeriod / 2) clk = ~clk;

  maxlog_siso #(.SW(SW), .MW(MW), .OW(OW), .MAX_LEN(ML)) i_maxlog_siso (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inLast(inLast), .inSys(inSys), .inPar(inPar), .inApr(inApr),
    .llrValid0(llrValid0), .llrIdx0(llrIdx0), .llr0(llr0),
    .llrValid1(llrValid1), .llrIdx1(llrIdx1), .llr1(llr1), .done(done)
  );

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;
  int  sysV [ML];
  int  parV [ML];
  int  aprV [ML];
  int  refL [ML];
  int  seen [ML];
  real al [ML+1][8];
  real be [ML+1][8];
  int unsigned lcg = 32'h1234_5678;
  localparam real NegR = -(2.0 ** (MW - 2));
  localparam int SatHi = 2 ** (OW - 1) - 1;
  localparam int SatLo = -(2 ** (OW - 1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R3: trellis written from the requirement
  function automatic int bnext(int s, int u);
    int s1, s2, s3, a;
    s1 = (s >> 2) & 1; s2 = (s >> 1) & 1; s3 = s & 1;
    a = u ^ s2 ^ s3;
    return a * 4 + s1 * 2 + s2;
  endfunction

  function automatic int bpar(int s, int u);
    int s1, s2, s3, a;
    s1 = (s >> 2) & 1; s2 = (s >> 1) & 1; s3 = s & 1;
    a = u ^ s2 ^ s3;
    return a ^ s1 ^ s3;
  endfunction

  // R2: branch metric
  function automatic real gam(int k, int u, int p);
    return real'(u * (sysV[k] + aprV[k]) + p * parV[k]);
  endfunction

  function automatic int rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) & 32'd63) - 32;
  endfunction

  // R4 start values, R5 max-log, floating point, no normalisation
  task automatic computeRef(input int n);
    real v, m1, m0, d;
    int  ns;
    for (int s = 0; s < 8; s++) begin
      al[0][s] = (s == 0) ? 0.0 : NegR;
      be[n][s] = (s == 0) ? 0.0 : NegR;
    end
    for (int k = 0; k < n; k++) begin
      for (int s = 0; s < 8; s++) al[k+1][s] = -1.0e30;
      for (int s = 0; s < 8; s++)
        for (int u = 0; u < 2; u++) begin
          ns = bnext(s, u);
          v = al[k][s] + gam(k, u, bpar(s, u));
          if (v > al[k+1][ns]) al[k+1][ns] = v;
        end
    end
    for (int k = n - 1; k >= 0; k--)
      for (int s = 0; s < 8; s++) begin
        be[k][s] = -1.0e30;
        for (int u = 0; u < 2; u++) begin
          v = gam(k, u, bpar(s, u)) + be[k+1][bnext(s, u)];
          if (v > be[k][s]) be[k][s] = v;
        end
      end
    for (int k = 0; k < n; k++) begin
      m1 = -1.0e30; m0 = -1.0e30;
      for (int s = 0; s < 8; s++)
        for (int u = 0; u < 2; u++) begin
          v = al[k][s] + gam(k, u, bpar(s, u)) + be[k+1][bnext(s, u)];
          if (u == 1) begin if (v > m1) m1 = v; end
          else begin if (v > m0) m0 = v; end
        end
      d = m1 - m0;
      // R6 saturation
      if (d > real'(SatHi)) d = real'(SatHi);
      if (d < real'(SatLo)) d = real'(SatLo);
      refL[k] = $rtoi(d);
    end
  endtask

  task automatic checkLane(input int idx, input logic [OW-1:0] val);
    int act;
    act = int'($signed(val));
    if (idx >= 0 && idx < ML) begin
      if (refL[idx] == SatHi || refL[idx] == SatLo)
        chk(act == refL[idx], "R6 saturated llr", act, refL[idx]);
      else
        chk(act == refL[idx], "R5 llr value", act, refL[idx]);
      seen[idx]++;
    end
  endtask

  task automatic runFrame(input int n, input int pat, input bit useLast);
    int  cyc;
    bit  gotDone;
    for (int k = 0; k < n; k++) begin
      case (pat)
        0: begin sysV[k] = rnd(); parV[k] = rnd(); aprV[k] = rnd(); end
        1: begin sysV[k] = 20; parV[k] = (k % 2 == 1) ? 25 : -25; aprV[k] = 0; end
        2: begin sysV[k] = (k % 2 == 1) ? -32 : 31; parV[k] = -32; aprV[k] = 31; end
        default: begin sysV[k] = 0; parV[k] = 0; aprV[k] = 0; end
      endcase
      seen[k] = 0;
    end
    computeRef(n);
    // R10: block ready for a new frame
    chk(inReady == 1'b1, "R10 ready before frame", int'(inReady), 1);
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1;
      inSys   = SW'(sysV[i]);
      inPar   = SW'(parV[i]);
      inApr   = SW'(aprV[i]);
      inLast  = useLast && (i == n - 1);
      @(posedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    if (useLast)
      chk(inReady == 1'b0, "R1 ready low while decoding", int'(inReady), 0);
    else
      chk(inReady == 1'b0, "R9 frame closed at capacity", int'(inReady), 0);
    cyc = 0;
    gotDone = 0;
    while (!gotDone && cyc < 4 * n + 10) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (llrValid1) begin
        // R7 lane pairing
        chk(int'(llrIdx1) == n - 1 - int'(llrIdx0), "R7 lane1 index",
            int'(llrIdx1), n - 1 - int'(llrIdx0));
        checkLane(int'(llrIdx1), llr1);
      end
      if (llrValid0) begin
        if (2 * int'(llrIdx0) == n - 1)
          chk(llrValid1 == 1'b0, "R7 middle step single lane", int'(llrValid1), 0);
        checkLane(int'(llrIdx0), llr0);
      end
      if (done) begin
        gotDone = 1;
        chk(inReady == 1'b1, "R1 ready with done", int'(inReady), 1);
      end
    end
    chk(gotDone && cyc == 2 * n, "R8 done cycle", cyc, 2 * n);
    for (int k = 0; k < n; k++)
      chk(seen[k] == 1, "R7 bit emitted once", seen[k], 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(inReady == 1'b1, "R1 reset inReady", int'(inReady), 1);
    chk(llrValid0 == 1'b0, "R1 reset llrValid0", int'(llrValid0), 0);
    chk(llrValid1 == 1'b0, "R1 reset llrValid1", int'(llrValid1), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    // sweep of lengths and patterns, frames back to back (R10)
    for (int n = 1; n <= 24; n++)
      for (int pat = 0; pat < 4; pat++)
        runFrame(n, pat, 1'b1);
    runFrame(ML, 0, 1'b1);
    // R9: capacity ends the frame without inLast
    runFrame(ML, 2, 1'b0);
    runFrame(5, 0, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule